// File: doc/BRIEF.md
# Pushbuffer Method Stream Parser

This block takes a stream of 32-bit command words and turns it into method calls for the engines behind it. A header word opens a command. It names a method address, a subchannel, a data-word count and a submission mode. The data words that follow are bound to method addresses according to that mode. Each call comes out as one registered record with these fields:

- the method address
- the subchannel
- the data argument
- the number of data words still owed to the command, counting the current one
- a last flag

The parser supports four submission modes:

- **Increasing:** the method address steps once per data word.
- **Non-increasing:** every data word targets the same address.
- **Increase-once:** the first word goes to the header's method and every later word goes to method+1.
- **Inline:** the header carries its own single argument and no data words follow.

A run of words aimed at one fixed address is grouped into bursts. The feeder supplies, with each word, how many words remain in the current fetch segment. The first word of a burst reports the burst length, which is bounded both by that figure and by the count the command still owes.

Top module: `pb_method_parser`

## Requirements
- R1: After reset, and after a reset applied in the middle of a command, no call is presented and the next accepted word is decoded as a header.
- R2: Header layout is: mode in bits [31:29], count in bits [28:16], subchannel in bits [15:13], method in bits [11:0]; bit 12 is ignored. Mode code 1 (increasing) sends data word k (from 0) to method+k, wrapping modulo 4096.
- R3: Mode code 3 (non-increasing) sends every data word of the command to the header's method.
- R4: Mode code 5 (increase-once) sends the first data word to the header's method and all later ones to method+1; those later words are handled as a non-incrementing run.
- R5: Mode code 4 (inline) emits one call at once, with the header's method and subchannel, the 13-bit count field zero-extended as the argument, a remaining value of 0 and the last flag set. The next word is decoded as a header.
- R6: Each data call reports the remaining count before that word is consumed; it drops by exactly one per data word.
- R7: For increasing words and the first increase-once word, the last flag is set exactly when the reported remaining count is 1.
- R8: For a non-incrementing run, a burst starts at the first word after the previous burst ended. That word sets the burst-start flag and reports a length of min(remaining, max(avail, 1)). Only the final word of each burst carries the last flag. Non-start words report a length of 0.
- R9: A header with mode code 0, 2, 6 or 7 emits no call and leaves the parser expecting a header.
- R10: A header in mode 1, 3 or 5 with a count of zero emits no call and leaves the parser expecting a header.
- R11: Every call carries the subchannel of the header that opened its command.
- R12: A call appears on the outputs in the cycle after its word is accepted. A cycle without an accepted word emits no call and leaves the command state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream word is presented this cycle |
| in_word | input | 32 | Stream word (header or data) |
| in_avail | input | AVL_W (13) | Words left in the current fetch segment, including this one |
| call_valid | output | 1 | A method call is presented |
| call_method | output | METH_W (12) | Method address of the call |
| call_subch | output | SUB_W (3) | Subchannel of the call |
| call_arg | output | 32 | Argument of the call |
| call_rem | output | CNT_W (13) | Data words still owed to the command, counting this one |
| call_last | output | 1 | Final call of the command or of the current burst |
| call_burst_start | output | 1 | First word of a non-incrementing burst |
| call_burst_len | output | CNT_W (13) | Burst length on a burst-start call, else 0 |

## Verification
The hardest situation to reach is a burst that ends before its command does. A new burst must then open on the next word at the same method. This happens only when the segment size on a word inside a non-incrementing run is smaller than the count still owed. The stimulus therefore lowers in_avail partway through such runs, including a value of zero.

The stimulus also drives the same run through an increase-once command, where the burst logic takes over after the first word. It inserts idle cycles inside an open burst, and applies a reset between a header and its final data word. The reset is followed by a word that would pass as data if the count had survived.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_INC    = 3'd1,
    MD_NONINC = 3'd3,
    MD_INLINE = 3'd4,
    MD_ONCE   = 3'd5
  } pb_mode_e;

  typedef enum logic [1:0] {
    ST_INC    = 2'd0,
    ST_NONINC = 2'd1,
    ST_ONCE   = 2'd2
  } pb_step_e;
endpackage

// File: rtl/pb_hdr_decode.sv
module pb_hdr_decode
  import pb_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic [MODE_W-1:0] mode_f,
  input  logic [CNT_W-1:0]  cnt_f,
  output logic              hdr_load,
  output logic              hdr_inline,
  output pb_step_e          hdr_step
);
  logic known_run;

  always_comb begin
    known_run = 1'b0;
    hdr_step  = ST_INC;
    hdr_inline = 1'b0;
    case (pb_mode_e'(mode_f))
      MD_INC:    begin known_run = 1'b1; hdr_step = ST_INC;    end
      MD_NONINC: begin known_run = 1'b1; hdr_step = ST_NONINC; end
      MD_ONCE:   begin known_run = 1'b1; hdr_step = ST_ONCE;   end
      MD_INLINE: hdr_inline = 1'b1;
      default:   ;
    endcase
    hdr_load = known_run && (cnt_f != '0);
  end
endmodule

// File: rtl/pb_burst_track.sv
module pb_burst_track #(
  parameter int CNT_W = 13,
  parameter int AVL_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] rem,
  input  logic [AVL_W-1:0] avail,
  output logic             b_start,
  output logic [CNT_W-1:0] b_len,
  output logic             b_fin
);
  localparam int LW = (CNT_W > AVL_W) ? CNT_W : AVL_W;

  logic [CNT_W-1:0] left_q;
  logic [LW-1:0]    rem_x, av_x, len_x;

  always_comb begin
    rem_x   = LW'(rem);
    av_x    = (avail == '0) ? LW'(1) : LW'(avail);
    len_x   = (rem_x < av_x) ? rem_x : av_x;
    b_start = take && (left_q == '0);
    b_len   = CNT_W'(len_x);
    b_fin   = (left_q == '0) ? (b_len == CNT_W'(1)) : (left_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (take) begin
      left_q <= b_start ? (b_len - CNT_W'(1)) : (left_q - CNT_W'(1));
    end
  end

  // R8: a burst never claims more words than the command still owes
  a_r8_len_within_rem: assert property (@(posedge clk) disable iff (rst)
    b_start |-> (b_len != '0) && (b_len <= rem));
  // R8: inside an open burst each word counts the remaining burst down by one
  a_r8_left_counts_down: assert property (@(posedge clk) disable iff (rst)
    (take && left_q != '0) |=> left_q == CNT_W'($past(left_q) - CNT_W'(1)));
endmodule

// File: rtl/pb_method_parser.sv
module pb_method_parser
  import pb_pkg::*;
#(
  parameter int METH_W = 12,
  parameter int SUB_W  = 3,
  parameter int CNT_W  = 13,
  parameter int AVL_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [AVL_W-1:0]  in_avail,
  output logic              call_valid,
  output logic [METH_W-1:0] call_method,
  output logic [SUB_W-1:0]  call_subch,
  output logic [WORD_W-1:0] call_arg,
  output logic [CNT_W-1:0]  call_rem,
  output logic              call_last,
  output logic              call_burst_start,
  output logic [CNT_W-1:0]  call_burst_len
);
  localparam int MODE_LSB = WORD_W - MODE_W;
  localparam int CNT_LSB  = MODE_LSB - CNT_W;
  localparam int SUB_LSB  = CNT_LSB - SUB_W;

  logic [METH_W-1:0] meth_q;
  logic [SUB_W-1:0]  sub_q;
  logic [CNT_W-1:0]  rem_q;
  pb_step_e          step_q;

  logic [MODE_W-1:0] f_mode;
  logic [CNT_W-1:0]  f_cnt;
  logic [SUB_W-1:0]  f_sub;
  logic [METH_W-1:0] f_meth;
  logic              hdr_load, hdr_inline;
  pb_step_e          hdr_step;
  logic              busy, b_take, b_start, b_fin;
  logic [CNT_W-1:0]  b_len;

  assign f_mode = in_word[MODE_LSB +: MODE_W];
  assign f_cnt  = in_word[CNT_LSB +: CNT_W];
  assign f_sub  = in_word[SUB_LSB +: SUB_W];
  assign f_meth = in_word[METH_W-1:0];
  assign busy   = (rem_q != '0);
  assign b_take = in_valid && busy && (step_q == ST_NONINC);

  pb_hdr_decode #(.CNT_W(CNT_W)) u_dec (
    .mode_f(f_mode), .cnt_f(f_cnt),
    .hdr_load(hdr_load), .hdr_inline(hdr_inline), .hdr_step(hdr_step)
  );

  pb_burst_track #(.CNT_W(CNT_W), .AVL_W(AVL_W)) u_burst (
    .clk(clk), .rst(rst), .take(b_take), .rem(rem_q), .avail(in_avail),
    .b_start(b_start), .b_len(b_len), .b_fin(b_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      meth_q <= '0; sub_q <= '0; rem_q <= '0; step_q <= ST_INC;
      call_valid <= 1'b0; call_method <= '0; call_subch <= '0; call_arg <= '0;
      call_rem <= '0; call_last <= 1'b0; call_burst_start <= 1'b0; call_burst_len <= '0;
    end else begin
      call_valid       <= 1'b0;
      call_burst_start <= 1'b0;
      call_burst_len   <= '0;
      if (in_valid) begin
        if (busy) begin
          call_valid  <= 1'b1;
          call_method <= meth_q;
          call_subch  <= sub_q;
          call_arg    <= in_word;
          call_rem    <= rem_q;
          rem_q       <= rem_q - CNT_W'(1);
          case (step_q)
            ST_INC: begin
              meth_q    <= meth_q + METH_W'(1);
              call_last <= (rem_q == CNT_W'(1));
            end
            ST_ONCE: begin
              meth_q    <= meth_q + METH_W'(1);
              step_q    <= ST_NONINC;
              call_last <= (rem_q == CNT_W'(1));
            end
            default: begin
              call_burst_start <= b_start;
              call_burst_len   <= b_start ? b_len : '0;
              call_last        <= b_fin;
            end
          endcase
        end else if (hdr_load) begin
          meth_q <= f_meth;
          sub_q  <= f_sub;
          rem_q  <= f_cnt;
          step_q <= hdr_step;
        end else if (hdr_inline) begin
          call_valid  <= 1'b1;
          call_method <= f_meth;
          call_subch  <= f_sub;
          call_arg    <= WORD_W'(f_cnt);
          call_rem    <= '0;
          call_last   <= 1'b1;
        end
      end
    end
  end

  // R12: no accepted word, no call
  a_r12_no_word_no_call: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> !call_valid);
  // R12: an idle cycle leaves the command state untouched
  a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(rem_q) && $stable(meth_q));
  // R7: the word that empties a command is flagged last
  a_r7_final_is_last: assert property (@(posedge clk) disable iff (rst)
    (call_valid && call_rem == CNT_W'(1)) |-> call_last);
  // R5: only inline calls report zero remaining, and they are last
  a_r5_inline_last: assert property (@(posedge clk) disable iff (rst)
    (call_valid && call_rem == '0) |-> call_last && !call_burst_start);
  // R3: within a non-incrementing command the target does not move
  a_r3_fixed_target: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rem_q > CNT_W'(1) && step_q == ST_NONINC) |=> $stable(meth_q));
  // R4: the first increase-once word steps once, then stepping stops
  a_r4_step_once: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy && step_q == ST_ONCE) |=>
      (step_q == ST_NONINC) && (meth_q == METH_W'($past(meth_q) + METH_W'(1))));
endmodule

// File: tb/pb_method_parser_tb.sv
module pb_method_parser_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        v;
    logic [31:0] w;
    logic [12:0] av;
    logic        ev;
    logic [11:0] em;
    logic [2:0]  es;
    logic [31:0] ea;
    logic [12:0] er;
    logic        el;
    logic        eb;
    logic [12:0] ebl;
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [31:0] H(int md, int cnt, int sub, int meth);
    return {md[2:0], cnt[12:0], sub[2:0], 1'b0, meth[11:0]};
  endfunction

  function automatic vec_t E(logic v, logic [31:0] w, int av, logic ev, int em, int es,
                             logic [31:0] ea, int er, logic el, logic eb, int ebl, int rq);
    return '{v, w, av[12:0], ev, em[11:0], es[2:0], ea, er[12:0], el, eb, ebl[12:0], rq[3:0]};
  endfunction

  function automatic string tag(logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    E(1, H(1,3,2,'h100), 9, 0, 0,0,0,0,0,0,0, 2),
    E(1, 32'h1111_0001, 9, 1, 'h100,2,32'h1111_0001,3,0,0,0, 2),
    E(1, 32'h1111_0002, 9, 1, 'h101,2,32'h1111_0002,2,0,0,0, 6),
    E(1, 32'h1111_0003, 9, 1, 'h102,2,32'h1111_0003,1,1,0,0, 7),
    E(1, H(3,4,5,'h040), 5, 0, 0,0,0,0,0,0,0, 3),
    E(1, 32'h2222_0001, 2, 1, 'h040,5,32'h2222_0001,4,0,1,2, 8),
    E(1, 32'h2222_0002, 1, 1, 'h040,5,32'h2222_0002,3,1,0,0, 8),
    E(1, 32'h2222_0003, 7, 1, 'h040,5,32'h2222_0003,2,0,1,2, 8),
    E(1, 32'h2222_0004, 6, 1, 'h040,5,32'h2222_0004,1,1,0,0, 3),
    E(0, 32'hFFFF_FFFF, 0, 0, 0,0,0,0,0,0,0, 12),
    E(1, H(5,3,1,'h0FF), 3, 0, 0,0,0,0,0,0,0, 4),
    E(1, 32'h3333_0001, 3, 1, 'h0FF,1,32'h3333_0001,3,0,0,0, 4),
    E(1, 32'h3333_0002, 4, 1, 'h100,1,32'h3333_0002,2,0,1,2, 4),
    E(0, 32'h3333_00FF, 0, 0, 0,0,0,0,0,0,0, 12),
    E(1, 32'h3333_0003, 3, 1, 'h100,1,32'h3333_0003,1,1,0,0, 4),
    E(1, H(4,'h1ABC,3,'h123), 1, 1, 'h123,3,32'h0000_1ABC,0,1,0,0, 5),
    E(1, H(2,5,1,'h010), 1, 0, 0,0,0,0,0,0,0, 9),
    E(1, H(7,5,1,'h010), 1, 0, 0,0,0,0,0,0,0, 9),
    E(1, H(0,5,1,'h010), 1, 0, 0,0,0,0,0,0,0, 9),
    E(1, H(1,0,1,'h010), 1, 0, 0,0,0,0,0,0,0, 10),
    E(1, H(3,0,1,'h010), 1, 0, 0,0,0,0,0,0,0, 10),
    E(1, H(1,1,0,'hFFF), 1, 0, 0,0,0,0,0,0,0, 2),
    E(1, 32'h4444_0001, 1, 1, 'hFFF,0,32'h4444_0001,1,1,0,0, 7),
    E(1, H(1,2,7,'hFFF), 2, 0, 0,0,0,0,0,0,0, 11),
    E(1, 32'h5555_0001, 2, 1, 'hFFF,7,32'h5555_0001,2,0,0,0, 11),
    E(1, 32'h5555_0002, 1, 1, 'h000,7,32'h5555_0002,1,1,0,0, 2),
    E(1, H(3,3,4,'h010), 3, 0, 0,0,0,0,0,0,0, 3),
    E(1, 32'h6666_0001, 0, 1, 'h010,4,32'h6666_0001,3,1,1,1, 8),
    E(1, 32'h6666_0002, 9, 1, 'h010,4,32'h6666_0002,2,0,1,2, 8),
    E(1, 32'h6666_0003, 8, 1, 'h010,4,32'h6666_0003,1,1,0,0, 8),
    E(1, H(5,1,6,'h020), 1, 0, 0,0,0,0,0,0,0, 4),
    E(1, 32'h7777_0001, 1, 1, 'h020,6,32'h7777_0001,1,1,0,0, 4),
    E(1, H(4,0,0,'h007), 1, 1, 'h007,0,32'h0000_0000,0,1,0,0, 5),
    E(1, 32'h0000_0000, 1, 0, 0,0,0,0,0,0,0, 5),
    E(1, H(5,0,2,'h030), 1, 0, 0,0,0,0,0,0,0, 10)
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [12:0] in_avail = '0;
  logic        call_valid, call_last, call_burst_start;
  logic [11:0] call_method;
  logic [2:0]  call_subch;
  logic [31:0] call_arg;
  logic [12:0] call_rem, call_burst_len;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pb_method_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_avail(in_avail),
    .call_valid(call_valid), .call_method(call_method), .call_subch(call_subch),
    .call_arg(call_arg), .call_rem(call_rem), .call_last(call_last),
    .call_burst_start(call_burst_start), .call_burst_len(call_burst_len)
  );

  task automatic check_vec(vec_t e, int idx);
    logic [63:0] act, exp;
    n_checks++;
    if (!e.ev) begin
      if (call_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL %s vec %0d: call_valid act=%b exp=0", tag(e.rq), idx, call_valid);
      end
    end else begin
      act = {call_valid, call_method, call_subch, call_rem, call_last, call_burst_start,
             call_burst_len, 18'd0};
      exp = {1'b1, e.em, e.es, e.er, e.el, e.eb, e.ebl, 18'd0};
      if (act !== exp || call_arg !== e.ea) begin
        n_fail++;
        $display("FAIL %s vec %0d: act v=%b m=%h s=%0d a=%h r=%0d l=%b b=%b bl=%0d exp m=%h s=%0d a=%h r=%0d l=%b b=%b bl=%0d",
                 tag(e.rq), idx, call_valid, call_method, call_subch, call_arg, call_rem,
                 call_last, call_burst_start, call_burst_len,
                 e.em, e.es, e.ea, e.er, e.el, e.eb, e.ebl);
      end
    end
  endtask

  task automatic expect_bit(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic put(logic v, logic [31:0] w, logic [12:0] av);
    @(negedge clk);
    in_valid = v; in_word = w; in_avail = av;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expect_bit("R1", "call_valid during reset", call_valid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    n_checks++;
    if (call_valid !== 1'b0 || call_rem !== '0 || call_last !== 1'b0 || call_burst_start !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after reset: act v=%b r=%0d l=%b b=%b exp all zero",
               call_valid, call_rem, call_last, call_burst_start);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (i > 0) check_vec(TBL[i-1], i-1);
      in_valid = TBL[i].v; in_word = TBL[i].w; in_avail = TBL[i].av;
    end
    @(negedge clk);
    check_vec(TBL[NV-1], NV-1);
    in_valid = 1'b0;

    // R1: reset in the middle of an increasing command
    put(1'b1, H(1,5,0,'h200), 13'd5);
    put(1'b1, 32'h8888_0001, 13'd4);
    put(1'b0, 32'h0, 13'd0);
    rst = 1'b1;
    put(1'b0, 32'h0, 13'd0);
    expect_bit("R1", "call_valid while reset held", call_valid, 1'b0);
    rst = 1'b0;
    put(1'b1, H(4,'h55,2,'h0AA), 13'd1);
    @(negedge clk);
    in_valid = 1'b0;
    n_checks++;
    if (call_valid !== 1'b1 || call_method !== 12'h0AA || call_arg !== 32'h55 || call_subch !== 3'd2) begin
      n_fail++;
      $display("FAIL R1 header after mid-command reset: act v=%b m=%h a=%h s=%0d exp v=1 m=0aa a=00000055 s=2",
               call_valid, call_method, call_arg, call_subch);
    end
    @(negedge clk);
    expect_bit("R12", "no call after idle", call_valid, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R12 watchdog expired: act=running exp=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule